// File: doc/BRIEF.md
# Factorial Sequencer on a Four-Register Datapath

This block pairs a small general-purpose datapath with a fixed control machine. The datapath has four `DW`-bit registers. In each cycle it picks two of them as operands, passes them through an ALU, and can write the result back into any one of the four. The ALU offers four operations, selected by a 2-bit code: 0 adds, 1 subtracts, 2 multiplies (keeping only the low `DW` bits of the product) and 3 computes bitwise NAND. An equality flag reports whether the two selected operands are the same value.

The control machine cycles through three states in a fixed order: multiply, decrement and test. In every state it issues a complete control word: first operand select, second operand select, operation, write enable and write select. The multiply state sets R0 to R0*R1. The decrement state sets R1 to R1 plus R2, and R2 holds all ones. The test state writes nothing. It compares R1 against R3, which holds zero, and either leaves for the done state or loops back to multiply.

A synchronous reset samples the operand `n_i` and loads the start values. When the run finishes, R0 holds N! truncated to `DW` bits and `done_o` is high. The operand N must be at least 1. With N = 0 the loop counter wraps and does not reach zero in any practical time.

Top module: `fsq_top`

## Requirements
- R1: At every rising clock edge where `rst_i` is high, the registers load R0=1, R1=`n_i`, R2=all ones and R3=0, the machine enters the multiply state, and `done_o` is 0.
- R2: In the multiply state, R0 becomes the low `DW` bits of R0*R1 at the next edge. R1, R2 and R3 keep their values.
- R3: In the decrement state, R1 becomes R1 plus R2 (one less, modulo 2^DW) at the next edge. R0, R2 and R3 keep their values.
- R4: In the test state no register changes. If R1 equals R3, the next state is done. Otherwise the next state is multiply.
- R5: `done_o` is high exactly while the machine is in the done state. For N >= 1 it first rises 3*N clock edges after the last reset edge.
- R6: When `done_o` first rises, R0 = N! mod 2^DW, R1 = 0, R2 = all ones and R3 = 0.
- R7: Once in the done state, all registers hold their values and `done_o` stays high until the next reset.
- R8: A reset during a run, or after one has finished, abandons that run and starts again from the newly sampled `n_i`.
- R9: The multiply keeps only the low `DW` bits of the product. For example, with `DW`=32 and N=13 the result is 1932053504.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high; also loads the start values |
| n_i | input | DW | Operand N, sampled on reset edges |
| r0_o | output | DW | Register R0 (accumulated product) |
| r1_o | output | DW | Register R1 (loop counter) |
| r2_o | output | DW | Register R2 (minus one constant) |
| r3_o | output | DW | Register R3 (zero constant) |
| done_o | output | 1 | High while the sequence has finished |

## Verification
The main run is tried with several values of N:
- N=1 leaves the loop on the first test and never multiplies by anything but one.
- N=2 and N=3 catch mistakes in the order of the states or the loop count, through both the product and the exact edge on which `done_o` rises.
- Larger N values, up to 13, exercise multi-bit products and the low-bit truncation of the multiply.

A step-by-step run with N=4 checks each state's write and non-write registers separately. Further directed runs check that the done state holds, and that a reset in the middle of a run restarts cleanly with a new N.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    // ALU operation codes; encoding is part of the control word contract
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_NAND = 2'd3
    } alu_op_e;

    // Sequencer states, in execution order
    typedef enum logic [1:0] {
        ST_MUL  = 2'd0,
        ST_DEC  = 2'd1,
        ST_TEST = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    // Full micro-control word issued each cycle
    typedef struct packed {
        logic [1:0] a_sel;
        logic [1:0] b_sel;
        alu_op_e    op;
        logic       wen;
        logic [1:0] w_sel;
    } ctrl_word_t;

endpackage

// File: rtl/fsq_regfile.sv
module fsq_regfile
    import fsq_pkg::*;
#(
    parameter int unsigned DW   = 32,
    parameter int unsigned NREG = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [NREG-1:0][DW-1:0]  init_i,
    input  logic [SEL_W-1:0]         a_sel_i,
    input  logic [SEL_W-1:0]         b_sel_i,
    input  logic                     wen_i,
    input  logic [SEL_W-1:0]         w_sel_i,
    input  logic [DW-1:0]            wdata_i,
    output logic [DW-1:0]            a_o,
    output logic [DW-1:0]            b_o,
    output logic [NREG-1:0][DW-1:0]  regs_o
);
    localparam int unsigned SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } rf_state_t;

    rf_state_t rf_d;
    rf_state_t rf_q;
    logic [NREG-1:0] wr_hit;

    // One write strobe per register
    for (genvar g = 0; g < NREG; g++) begin : g_wr_dec
        assign wr_hit[g] = wen_i && (w_sel_i == SEL_W'(g));
    end

    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_hit[i]) begin
                rf_d.regs[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rf_q.regs <= init_i;
        end else begin
            rf_q <= rf_d;
        end
    end

    // Operand read ports
    assign a_o    = rf_q.regs[a_sel_i];
    assign b_o    = rf_q.regs[b_sel_i];
    assign regs_o = rf_q.regs;

endmodule

// File: rtl/fsq_alu.sv
module fsq_alu
    import fsq_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  alu_op_e       op_i,
    output logic [DW-1:0] y_o,
    output logic          eq_o
);
    logic [DW-1:0] sum;
    logic [DW-1:0] diff;
    logic [DW-1:0] prod;
    logic [DW-1:0] nand_v;

    assign sum    = a_i + b_i;
    assign diff   = a_i - b_i;
    assign prod   = a_i * b_i;  // low DW bits kept
    assign nand_v = ~(a_i & b_i);

    always_comb begin
        unique case (op_i)
            OP_ADD:  y_o = sum;
            OP_SUB:  y_o = diff;
            OP_MUL:  y_o = prod;
            OP_NAND: y_o = nand_v;
            default: y_o = sum;
        endcase
    end

    assign eq_o = (a_i == b_i);

endmodule

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
    import fsq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       eq_i,
    output ctrl_word_t ctrl_o,
    output seq_state_e state_o,
    output logic       done_o
);
    typedef struct packed {
        seq_state_e state;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{state: ST_MUL};

    ctl_state_t ctl_d;
    ctl_state_t ctl_q;
    ctrl_word_t cw;

    always_comb begin
        ctl_d = ctl_q;
        cw    = '{a_sel: 2'd1, b_sel: 2'd3, op: OP_ADD, wen: 1'b0, w_sel: 2'd0};
        unique case (ctl_q.state)
            ST_MUL: begin
                // R0 <- R0 * R1
                cw          = '{a_sel: 2'd0, b_sel: 2'd1, op: OP_MUL, wen: 1'b1, w_sel: 2'd0};
                ctl_d.state = ST_DEC;
            end
            ST_DEC: begin
                // R1 <- R1 + R2 (R2 holds minus one)
                cw          = '{a_sel: 2'd1, b_sel: 2'd2, op: OP_ADD, wen: 1'b1, w_sel: 2'd1};
                ctl_d.state = ST_TEST;
            end
            ST_TEST: begin
                // compare R1 with R3 (zero), no write
                cw          = '{a_sel: 2'd1, b_sel: 2'd3, op: OP_ADD, wen: 1'b0, w_sel: 2'd0};
                ctl_d.state = eq_i ? ST_DONE : ST_MUL;
            end
            ST_DONE: begin
                cw          = '{a_sel: 2'd1, b_sel: 2'd3, op: OP_ADD, wen: 1'b0, w_sel: 2'd0};
                ctl_d.state = ST_DONE;
            end
            default: ctl_d.state = ST_MUL;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctrl_o  = cw;
    assign state_o = ctl_q.state;
    assign done_o  = (ctl_q.state == ST_DONE);

endmodule

// File: rtl/fsq_top.sv
module fsq_top
    import fsq_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [DW-1:0] n_i,
    output logic [DW-1:0] r0_o,
    output logic [DW-1:0] r1_o,
    output logic [DW-1:0] r2_o,
    output logic [DW-1:0] r3_o,
    output logic          done_o
);
    localparam int unsigned NREG = 4;

    logic [NREG-1:0][DW-1:0] init_vals;
    logic [NREG-1:0][DW-1:0] regs;
    logic [DW-1:0]           opa;
    logic [DW-1:0]           opb;
    logic [DW-1:0]           alu_y;
    logic                    alu_eq;
    ctrl_word_t              cw;
    seq_state_e              seq_state;

    // Start values: product, counter, minus one, zero
    assign init_vals[0] = DW'(1);
    assign init_vals[1] = n_i;
    assign init_vals[2] = '1;
    assign init_vals[3] = '0;

    fsq_regfile #(
        .DW   (DW),
        .NREG (NREG)
    ) u_rf (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .init_i  (init_vals),
        .a_sel_i (cw.a_sel),
        .b_sel_i (cw.b_sel),
        .wen_i   (cw.wen),
        .w_sel_i (cw.w_sel),
        .wdata_i (alu_y),
        .a_o     (opa),
        .b_o     (opb),
        .regs_o  (regs)
    );

    fsq_alu #(
        .DW (DW)
    ) u_alu (
        .a_i  (opa),
        .b_i  (opb),
        .op_i (cw.op),
        .y_o  (alu_y),
        .eq_o (alu_eq)
    );

    fsq_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .eq_i    (alu_eq),
        .ctrl_o  (cw),
        .state_o (seq_state),
        .done_o  (done_o)
    );

    assign r0_o = regs[0];
    assign r1_o = regs[1];
    assign r2_o = regs[2];
    assign r3_o = regs[3];

endmodule

// File: rtl/fsq_chk.sv
module fsq_chk
    import fsq_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input logic          clk_i,
    input logic          rst_i,
    input seq_state_e    state_i,
    input logic [DW-1:0] r0_i,
    input logic [DW-1:0] r1_i,
    input logic [DW-1:0] r2_i,
    input logic [DW-1:0] r3_i,
    input logic          done_i
);
    AST_MUL_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_MUL) |=> (r0_i == DW'($past(r0_i) * $past(r1_i))) && $stable(r1_i) && $stable(r2_i)) // R2
        else $error("multiply step wrong");

    AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_DEC) |=> (r1_i == DW'($past(r1_i) - DW'(1))) && $stable(r0_i) && $stable(r3_i)) // R3
        else $error("decrement step wrong");

    AST_TEST_NO_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_TEST) |=> $stable(r0_i) && $stable(r1_i) && $stable(r2_i) && $stable(r3_i)) // R4
        else $error("test state wrote a register");

    AST_TEST_EXIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_TEST && r1_i == r3_i) |=> done_i) // R4
        else $error("test did not exit on zero");

    AST_TEST_LOOP: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_i == ST_TEST && r1_i != r3_i) |=> (state_i == ST_MUL) && !done_i) // R4
        else $error("test did not loop back");

    AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        done_i |=> done_i && $stable(r0_i) && $stable(r1_i)) // R7
        else $error("done state not held");

    AST_DONE_RESULT: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(done_i) |-> (r1_i == '0) && (r2_i == '1) && (r3_i == '0)) // R6
        else $error("done entered with wrong registers");

endmodule

bind fsq_top fsq_chk #(.DW(DW)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .state_i (seq_state),
    .r0_i    (r0_o),
    .r1_i    (r1_o),
    .r2_i    (r2_o),
    .r3_i    (r3_o),
    .done_i  (done_o)
);

// File: tb/fsq_top_tb_top.sv
module fsq_top_tb_top;
    localparam int unsigned DW = 32;
    localparam int          NV = 7;

    // Vector table: N and expected N! mod 2^32
    localparam logic [31:0] VEC_N [NV] = '{32'd1, 32'd2, 32'd3, 32'd5, 32'd10, 32'd12, 32'd13};
    localparam logic [31:0] VEC_F [NV] = '{32'd1, 32'd2, 32'd6, 32'd120, 32'd3628800,
                                           32'd479001600, 32'd1932053504};

    logic          clk;
    logic          rst;
    logic [DW-1:0] n_in;
    logic [DW-1:0] r0, r1, r2, r3;
    logic          done;

    int n_checks = 0;
    int n_fail   = 0;

    fsq_top #(.DW(DW)) dut_i (
        .clk_i  (clk),
        .rst_i  (rst),
        .n_i    (n_in),
        .r0_o   (r0),
        .r1_o   (r1),
        .r2_o   (r2),
        .r3_o   (r3),
        .done_o (done)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply one reset edge with the given N; returns at the next falling edge
    task automatic do_reset(input logic [31:0] n);
        @(negedge clk);
        rst  = 1'b1;
        n_in = n;
        @(negedge clk);
        rst  = 1'b0;
    endtask

    // Counts edges until done rises (limit guards a hang)
    task automatic wait_done(output int edges);
        edges = 0;
        while (!done && edges < 200) begin
            @(negedge clk);
            edges++;
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int edges;
        logic [31:0] held;
        rst  = 1'b1;
        n_in = 32'd7;

        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        check("R1 r0", r0, 32'd1);
        check("R1 r1", r1, 32'd7);
        check("R1 r2", r2, 32'hFFFF_FFFF);
        check("R1 r3", r3, 32'd0);
        check("R1 done", 32'(done), 32'd0);

        // Table walk: R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            do_reset(VEC_N[i]);
            wait_done(edges);
            check("R5 cycles", edges, 3 * VEC_N[i]);
            check("R6 r0 result", r0, VEC_F[i]);
            check("R6 r1", r1, 32'd0);
            check("R6 r2", r2, 32'hFFFF_FFFF);
            check("R6 r3", r3, 32'd0);
            if (VEC_N[i] == 32'd13) check("R9 truncation", r0, 32'd1932053504);
        end

        // Step-by-step with N=4
        do_reset(32'd4);
        @(negedge clk);
        check("R2 r0 after mul", r0, 32'd4);
        check("R2 r1 unchanged", r1, 32'd4);
        @(negedge clk);
        check("R3 r1 after dec", r1, 32'd3);
        check("R3 r0 unchanged", r0, 32'd4);
        @(negedge clk);
        check("R4 r0 in test", r0, 32'd4);
        check("R4 r1 in test", r1, 32'd3);
        check("R4 no done", 32'(done), 32'd0);
        @(negedge clk);
        check("R4 loop to mul r0", r0, 32'd12);

        // R7: hold in done
        wait_done(edges);
        held = r0;
        check("R7 result N=4", held, 32'd24);
        for (int k = 0; k < 10; k++) @(negedge clk);
        check("R7 done held", 32'(done), 32'd1);
        check("R7 r0 held", r0, held);
        check("R7 r1 held", r1, 32'd0);

        // R8: reset after done, and mid-run reset
        do_reset(32'd5);
        check("R8 done cleared", 32'(done), 32'd0);
        for (int k = 0; k < 7; k++) @(negedge clk);
        do_reset(32'd3);
        check("R8 r0 restart", r0, 32'd1);
        check("R8 r1 restart", r1, 32'd3);
        wait_done(edges);
        check("R8 cycles", edges, 32'd9);
        check("R8 result", r0, 32'd6);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule